// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block performs the entry half of an interrupt in a flat 16-bit segmented environment. When a request is accepted it saves the interrupted context on the stack and redirects execution through a vector table. It takes a snapshot of the current stack segment, stack pointer, code segment, instruction pointer and flag word. It then writes three words onto a word-wide stack memory: the flag word first, then the code segment, then the return instruction pointer. Next it reads a two-word entry from a vector table at address 0, and finally presents the updated register values for the surrounding core to load.

A request is one of three kinds. A numbered interrupt names any vector from 0 to 255. A breakpoint always uses vector 3. An overflow trap uses vector 4, and it is taken only when the overflow flag of the snapshot is set; otherwise it completes at once and changes nothing. If the stack pointer is 1, 3 or 5, the three pushes cannot fit. The block then enters a sticky shutdown state instead of performing the entry, and only reset leaves that state.

The memory port is synchronous. A read presents its data in the cycle after the request. Every access uses a 20-bit byte address.

Top module: `rm_irq_entry`

## Requirements
- R1: A taken request performs three writes in consecutive cycles. They go to byte addresses (SS*16 + SP - 2), (SS*16 + SP - 4) and (SS*16 + SP - 6), each wrapped to 20 bits and each with SP wrapped to 16 bits. The data written are, in order, the flag word, the code segment and the return IP.
- R2: The pushed flag word is the snapshot unchanged. After an entry, flags_out equals the snapshot with bit 9 (interrupt enable) and bit 8 (trap) cleared and every other bit kept.
- R3: After the pushes, the block reads byte address vector*4 and then vector*4+2. The first word becomes ip_out and the second becomes cs_out. sp_out equals the snapshot SP minus 6.
- R4: req_kind selects the vector. 2'b00 and 2'b11 use req_vector. 2'b01 (breakpoint) uses vector 3 and ignores req_vector. 2'b10 (overflow trap) uses vector 4.
- R5: An overflow-trap request whose flag bit 11 is 0 makes no memory access and pulses done one cycle after acceptance. In that case the four register outputs equal the snapshot values.
- R6: A taken request with SP equal to 1, 3 or 5 raises shutdown in the cycle after acceptance and makes no memory access. Shutdown stays high until reset, and every request while it is high is ignored.
- R7: busy is high from the cycle after acceptance until the cycle in which done pulses for one cycle, and busy is low during that pulse. A request that arrives while busy is high is ignored.
- R8: After reset, busy, done, shutdown and mem_en are 0, and all four register outputs are 0.
- R9: An entry makes exactly five memory accesses, three writes followed by two reads. No error code or other word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_kind | input | 2 | Request kind: numbered, breakpoint, overflow trap |
| req_vector | input | 8 | Vector number for a numbered request |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| flags_in | input | 16 | Current flag word |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse: register outputs updated |
| shutdown | output | 1 | Sticky low-stack shutdown |
| sp_out | output | 16 | New stack pointer |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New instruction pointer |
| flags_out | output | 16 | New flag word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 20 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |

## Verification
On every cycle, the assertions check that each stack write lands two bytes below the one before it, and that the second table read sits two bytes above the first. They also check that an entry ends with exactly three writes and with the interrupt-enable and trap bits clear. Shutdown must hold, must keep the memory port silent, and the port must stay quiet whenever busy is low. Only the bench scenarios can show that the written data and the vector selection are right: the push order of flags, code segment and return IP, the wrap of the address at 20 bits and of SP at 0, the breakpoint and overflow vectors, and the exact SP values 1, 3 and 5 that trigger shutdown next to 6, which does not. They also show that a request arriving mid-sequence leaves the result untouched.

// File: rtl/rm_irq_pkg.sv
package rm_irq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_FL = 3'd1,
      ST_PUSH_CS = 3'd2,
      ST_PUSH_IP = 3'd3,
      ST_RD_OFF  = 3'd4,
      ST_RD_SEL  = 3'd5,
      ST_CAP_SEL = 3'd6
   } seq_state_t;

   localparam logic [1:0] KIND_NUM = 2'b00;
   localparam logic [1:0] KIND_BRK = 2'b01;
   localparam logic [1:0] KIND_OVF = 2'b10;

   localparam int unsigned BRK_VECTOR = 3;
   localparam int unsigned OVF_VECTOR = 4;

endpackage

// File: rtl/rm_irq_decode.sv
module rm_irq_decode
   import rm_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned OF_BIT = 11
) (
   input  logic [1:0]        kind,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] sp_in,
   output logic [VEC_W-1:0]  vec_sel,
   output logic              take,
   output logic              low_stack
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned FRAME_BYTES = 3 * WORD_BYTES;

   always_comb begin
      unique case (kind)
         KIND_BRK: vec_sel = VEC_W'(BRK_VECTOR);
         KIND_OVF: vec_sel = VEC_W'(OVF_VECTOR);
         default:  vec_sel = vec_in;
      endcase
   end

   // the conditional trap is dropped when overflow is clear
   assign take = (kind != KIND_OVF) || flags_in[OF_BIT];

   // an odd pointer below one frame cannot hold the three pushes
   assign low_stack = (sp_in < DATA_W'(FRAME_BYTES)) && sp_in[0];

endmodule

// File: rtl/rm_irq_addr.sv
module rm_irq_addr
   import rm_irq_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned SEG_SHIFT  = 4,
   parameter int unsigned TABLE_BASE = 0
) (
   input  seq_state_t        state,
   input  logic [DATA_W-1:0] ss_c,
   input  logic [DATA_W-1:0] sp_c,
   input  logic [VEC_W-1:0]  vec_c,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned ENTRY_SH   = $clog2(2 * WORD_BYTES);

   logic [DATA_W-1:0] push_sp;
   logic [ADDR_W-1:0] seg_base;
   logic [ADDR_W-1:0] entry_addr;

   always_comb begin
      unique case (state)
         ST_PUSH_FL: push_sp = sp_c - DATA_W'(WORD_BYTES);
         ST_PUSH_CS: push_sp = sp_c - DATA_W'(2 * WORD_BYTES);
         ST_PUSH_IP: push_sp = sp_c - DATA_W'(3 * WORD_BYTES);
         default:    push_sp = sp_c;
      endcase
   end

   assign seg_base = ADDR_W'(ss_c) << SEG_SHIFT;

   generate
      if (TABLE_BASE == 0) begin : g_tbl_zero
         assign entry_addr = ADDR_W'(vec_c) << ENTRY_SH;
      end else begin : g_tbl_offset
         assign entry_addr = ADDR_W'(TABLE_BASE) + (ADDR_W'(vec_c) << ENTRY_SH);
      end
   endgenerate

   always_comb begin
      unique case (state)
         ST_RD_OFF: addr = entry_addr;
         ST_RD_SEL: addr = entry_addr + ADDR_W'(WORD_BYTES);
         default:   addr = seg_base + ADDR_W'(push_sp);
      endcase
   end

endmodule

// File: rtl/rm_irq_fsm.sv
module rm_irq_fsm
   import rm_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned IF_BIT = 9,
   parameter int unsigned TF_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              take,
   input  logic              low_stack,
   input  logic [VEC_W-1:0]  vec_sel,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output seq_state_t        state,
   output logic [DATA_W-1:0] ss_c,
   output logic [DATA_W-1:0] sp_c,
   output logic [VEC_W-1:0]  vec_c,
   output logic              mem_en,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done,
   output logic              shutdown,
   output logic [DATA_W-1:0] sp_out,
   output logic [DATA_W-1:0] cs_out,
   output logic [DATA_W-1:0] ip_out,
   output logic [DATA_W-1:0] flags_out
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam logic [DATA_W-1:0] CLR_MASK =
      ~((DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT));

   logic [DATA_W-1:0] cs_c, ip_c, fl_c, off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ss_c      <= '0;
         sp_c      <= '0;
         cs_c      <= '0;
         ip_c      <= '0;
         fl_c      <= '0;
         vec_c     <= '0;
         off_q     <= '0;
         done      <= 1'b0;
         shutdown  <= 1'b0;
         sp_out    <= '0;
         cs_out    <= '0;
         ip_out    <= '0;
         flags_out <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid && !shutdown) begin
                  ss_c  <= ss_in;
                  sp_c  <= sp_in;
                  cs_c  <= cs_in;
                  ip_c  <= ip_in;
                  fl_c  <= flags_in;
                  vec_c <= vec_sel;
                  if (!take) begin
                     sp_out    <= sp_in;
                     cs_out    <= cs_in;
                     ip_out    <= ip_in;
                     flags_out <= flags_in;
                     done      <= 1'b1;
                  end else if (low_stack) begin
                     shutdown <= 1'b1;
                  end else begin
                     state <= ST_PUSH_FL;
                  end
               end
            end
            ST_PUSH_FL: state <= ST_PUSH_CS;
            ST_PUSH_CS: state <= ST_PUSH_IP;
            ST_PUSH_IP: state <= ST_RD_OFF;
            ST_RD_OFF:  state <= ST_RD_SEL;
            ST_RD_SEL: begin
               off_q <= mem_rdata;
               state <= ST_CAP_SEL;
            end
            ST_CAP_SEL: begin
               cs_out    <= mem_rdata;
               ip_out    <= off_q;
               sp_out    <= sp_c - DATA_W'(3 * WORD_BYTES);
               flags_out <= fl_c & CLR_MASK;
               done      <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      unique case (state)
         ST_PUSH_FL: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = fl_c; end
         ST_PUSH_CS: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = cs_c; end
         ST_PUSH_IP: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = ip_c; end
         ST_RD_OFF, ST_RD_SEL: mem_en = 1'b1;
         default: ;
      endcase
   end

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rm_irq_entry.sv
module rm_irq_entry
   import rm_irq_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned SEG_SHIFT  = 4,
   parameter int unsigned TABLE_BASE = 0,
   parameter int unsigned OF_BIT     = 11,
   parameter int unsigned IF_BIT     = 9,
   parameter int unsigned TF_BIT     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] flags_in,
   output logic              busy,
   output logic              done,
   output logic              shutdown,
   output logic [DATA_W-1:0] sp_out,
   output logic [DATA_W-1:0] cs_out,
   output logic [DATA_W-1:0] ip_out,
   output logic [DATA_W-1:0] flags_out,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   initial begin
      if (DATA_W % 8 != 0) $error("data width must be whole bytes");
      if (ADDR_W < DATA_W) $error("address narrower than a data word");
      if (OF_BIT >= DATA_W || IF_BIT >= DATA_W || TF_BIT >= DATA_W)
         $error("flag bit outside the flag word");
      if (IF_BIT == TF_BIT) $error("enable and trap bits must differ");
      if (VEC_W < 3) $error("vector too narrow for the fixed vectors");
   end

   seq_state_t        state;
   logic [DATA_W-1:0] ss_c, sp_c;
   logic [VEC_W-1:0]  vec_c, vec_sel;
   logic              take, low_stack;

   rm_irq_decode #(
      .DATA_W (DATA_W),
      .VEC_W  (VEC_W),
      .OF_BIT (OF_BIT)
   ) decode_i (
      .kind      (req_kind),
      .vec_in    (req_vector),
      .flags_in  (flags_in),
      .sp_in     (sp_in),
      .vec_sel   (vec_sel),
      .take      (take),
      .low_stack (low_stack)
   );

   rm_irq_fsm #(
      .DATA_W (DATA_W),
      .VEC_W  (VEC_W),
      .IF_BIT (IF_BIT),
      .TF_BIT (TF_BIT)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .take      (take),
      .low_stack (low_stack),
      .vec_sel   (vec_sel),
      .ss_in     (ss_in),
      .sp_in     (sp_in),
      .cs_in     (cs_in),
      .ip_in     (ip_in),
      .flags_in  (flags_in),
      .mem_rdata (mem_rdata),
      .state     (state),
      .ss_c      (ss_c),
      .sp_c      (sp_c),
      .vec_c     (vec_c),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .busy      (busy),
      .done      (done),
      .shutdown  (shutdown),
      .sp_out    (sp_out),
      .cs_out    (cs_out),
      .ip_out    (ip_out),
      .flags_out (flags_out)
   );

   rm_irq_addr #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .VEC_W      (VEC_W),
      .SEG_SHIFT  (SEG_SHIFT),
      .TABLE_BASE (TABLE_BASE)
   ) addr_i (
      .state (state),
      .ss_c  (ss_c),
      .sp_c  (sp_c),
      .vec_c (vec_c),
      .addr  (mem_addr)
   );

endmodule

// File: rtl/rm_irq_entry_chk.sv
module rm_irq_entry_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned IF_BIT = 9,
   parameter int unsigned TF_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              shutdown,
   input logic [DATA_W-1:0] flags_out,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;

   logic [3:0] wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                wr_cnt <= '0;
      else if (done)             wr_cnt <= '0;
      else if (mem_en && mem_we) wr_cnt <= wr_cnt + 4'd1;
   end

   // R1: consecutive pushes step down one word
   a_r1_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && $past(mem_en && mem_we))
      |-> (mem_addr + ADDR_W'(WORD_BYTES)) == $past(mem_addr));

   // R3: selector read follows the offset read one word higher
   a_r3_table_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && $past(mem_en && !mem_we))
      |-> mem_addr == ($past(mem_addr) + ADDR_W'(WORD_BYTES)));

   // R2: an entry ends with enable and trap bits clear
   a_r2_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(busy)) |-> (!flags_out[IF_BIT] && !flags_out[TF_BIT]));

   // R9: exactly three pushes per entry
   a_r9_three_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(busy)) |-> wr_cnt == 4'd3);

   // R6: shutdown holds and keeps the port silent
   a_r6_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> shutdown);
   a_r6_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!mem_en && !busy));

   // R7: no access outside a sequence; done closes busy
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind rm_irq_entry rm_irq_entry_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IF_BIT (IF_BIT),
   .TF_BIT (TF_BIT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .shutdown  (shutdown),
   .flags_out (flags_out),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/rm_irq_entry_tb_top.sv
`timescale 1ns/1ps
module rm_irq_entry_tb_top;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [7:0]  req_vector = 8'h00;
   logic [15:0] ss_in = '0, sp_in = '0, cs_in = '0, ip_in = '0, flags_in = '0;
   logic        busy, done, shutdown, mem_en, mem_we;
   logic [15:0] sp_out, cs_out, ip_out, flags_out, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic [19:0] mem_addr;

   rm_irq_entry dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_vector(req_vector), .ss_in(ss_in), .sp_in(sp_in), .cs_in(cs_in),
      .ip_in(ip_in), .flags_in(flags_in), .busy(busy), .done(done),
      .shutdown(shutdown), .sp_out(sp_out), .cs_out(cs_out), .ip_out(ip_out),
      .flags_out(flags_out), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [15:0] mem [logic [19:0]];
   logic        q_we[$];
   logic [19:0] q_addr[$];
   logic [15:0] q_data[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory model: synchronous read, word stored per byte address
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] = mem_wdata;
         else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
      end
   end

   // monitor: every access is compared with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && mem_en) begin
         if (q_we.size() == 0) begin
            chk(1'b0, "R9", "unexpected access", {12'h0, mem_addr}, 32'h0);
         end else begin
            logic        e_we;
            logic [19:0] e_addr;
            logic [15:0] e_data;
            e_we   = q_we.pop_front();
            e_addr = q_addr.pop_front();
            e_data = q_data.pop_front();
            chk(mem_we == e_we, "R9", "access direction", {31'h0, mem_we}, {31'h0, e_we});
            chk(mem_addr == e_addr, e_we ? "R1" : "R3", "access address",
                {12'h0, mem_addr}, {12'h0, e_addr});
            if (e_we) chk(mem_wdata == e_data, "R1", "push data",
                          {16'h0, mem_wdata}, {16'h0, e_data});
         end
      end
   end

   function automatic logic [19:0] phys(input logic [15:0] ss, input logic [15:0] sp);
      return ({4'h0, ss} << 4) + {4'h0, sp};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_int(input logic [1:0] kind, input logic [7:0] vec,
                          input logic [15:0] ss, input logic [15:0] sp,
                          input logic [15:0] cs, input logic [15:0] ip,
                          input logic [15:0] fl, input bit inject);
      logic [7:0]  ev;
      logic [19:0] tb;
      logic [15:0] e_off, e_sel;
      bit take, low;
      ev   = (kind == 2'b01) ? 8'd3 : (kind == 2'b10) ? 8'd4 : vec;   // R4
      take = (kind != 2'b10) || fl[11];
      low  = take && (sp == 16'd1 || sp == 16'd3 || sp == 16'd5);
      tb   = {10'h0, ev, 2'b00};
      e_off = mem.exists(tb) ? mem[tb] : 16'h0;
      e_sel = mem.exists(tb + 20'd2) ? mem[tb + 20'd2] : 16'h0;
      if (take && !low) begin
         q_we.push_back(1'b1); q_addr.push_back(phys(ss, sp - 16'd2)); q_data.push_back(fl);
         q_we.push_back(1'b1); q_addr.push_back(phys(ss, sp - 16'd4)); q_data.push_back(cs);
         q_we.push_back(1'b1); q_addr.push_back(phys(ss, sp - 16'd6)); q_data.push_back(ip);
         q_we.push_back(1'b0); q_addr.push_back(tb);          q_data.push_back(16'h0);
         q_we.push_back(1'b0); q_addr.push_back(tb + 20'd2);  q_data.push_back(16'h0);
      end
      req_kind = kind; req_vector = vec;
      ss_in = ss; sp_in = sp; cs_in = cs; ip_in = ip; flags_in = fl;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == (take && !low), "R7", "busy after accept", {31'h0, busy},
          {31'h0, take && !low});
      if (inject) begin
         // R7: a request while busy must change nothing
         req_valid = 1'b1; req_kind = 2'b00; req_vector = 8'h55;
         sp_in = 16'h1234; flags_in = 16'h0000;
         @(negedge clk);
         req_valid = 1'b0;
      end
      for (int i = 0; i < 30; i++) begin
         if (done || shutdown) break;
         @(negedge clk);
      end
      if (low) begin
         chk(shutdown == 1'b1, "R6", "shutdown raised", {31'h0, shutdown}, 32'h1);
         chk(busy == 1'b0 && done == 1'b0, "R6", "no entry on low stack",
             {30'h0, busy, done}, 32'h0);
      end else if (!take) begin
         chk(done == 1'b1, "R5", "done on skipped trap", {31'h0, done}, 32'h1);
         chk(sp_out == sp && cs_out == cs && ip_out == ip && flags_out == fl, "R5",
             "outputs unchanged", {sp_out, ip_out}, {sp, ip});
      end else begin
         chk(done == 1'b1, "R7", "done pulse", {31'h0, done}, 32'h1);
         chk(busy == 1'b0, "R7", "busy low at done", {31'h0, busy}, 32'h0);
         chk(ip_out == e_off, "R3", "new ip", {16'h0, ip_out}, {16'h0, e_off});
         chk(cs_out == e_sel, "R3", "new cs", {16'h0, cs_out}, {16'h0, e_sel});
         chk(sp_out == sp - 16'd6, "R3", "new sp", {16'h0, sp_out}, {16'h0, sp - 16'd6});
         chk(flags_out == (fl & 16'hFCFF), "R2", "new flags",
             {16'h0, flags_out}, {16'h0, fl & 16'hFCFF});
         chk(mem[phys(ss, sp - 16'd2)] == fl, "R2", "pushed flags image",
             {16'h0, mem[phys(ss, sp - 16'd2)]}, {16'h0, fl});
         chk(mem[phys(ss, sp - 16'd6)] == ip, "R1", "pushed return ip",
             {16'h0, mem[phys(ss, sp - 16'd6)]}, {16'h0, ip});
      end
      chk(q_we.size() == 0, "R9", "all expected accesses seen",
          q_we.size(), 32'h0);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done is one cycle", {31'h0, done}, 32'h0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // vector table contents
      mem[20'h00084] = 16'h5678; mem[20'h00086] = 16'h9ABC;   // vector 0x21
      mem[20'h0000C] = 16'h1111; mem[20'h0000E] = 16'h2222;   // vector 3
      mem[20'h00010] = 16'h3333; mem[20'h00012] = 16'h4444;   // vector 4
      mem[20'h003FC] = 16'hAAAA; mem[20'h003FE] = 16'hBBBB;   // vector 255
      mem[20'h00000] = 16'hC0DE; mem[20'h00002] = 16'hF00D;   // vector 0

      do_reset();
      // R8 reset state
      chk(!busy && !done && !shutdown && !mem_en, "R8", "reset controls",
          {28'h0, busy, done, shutdown, mem_en}, 32'h0);
      chk(sp_out == 0 && cs_out == 0 && ip_out == 0 && flags_out == 0, "R8",
          "reset registers", {sp_out, ip_out}, 32'h0);

      // R1 R2 R3: numbered vector with enable and trap set
      run_int(2'b00, 8'h21, 16'h1000, 16'h0100, 16'h2000, 16'h0123, 16'h0302, 1'b0);
      // R4: breakpoint ignores the vector input; R7 request while busy
      run_int(2'b01, 8'h77, 16'h0400, 16'h0200, 16'h0ABC, 16'h0456, 16'h0246, 1'b1);
      // R4: overflow trap taken
      run_int(2'b10, 8'h99, 16'h0500, 16'h0080, 16'h1234, 16'h5678, 16'h0A00, 1'b0);
      // R5: overflow trap skipped
      run_int(2'b10, 8'h99, 16'h0600, 16'h0040, 16'h4321, 16'h8765, 16'h0202, 1'b0);
      // R1: 20-bit address wrap, vector 255 via kind 2'b11
      run_int(2'b11, 8'hFF, 16'hFFFF, 16'h0020, 16'h7777, 16'h8888, 16'hFFFF, 1'b0);
      // R1: SP wrap from 0, vector 0
      run_int(2'b00, 8'h00, 16'h3000, 16'h0000, 16'h0101, 16'h0202, 16'h0000, 1'b0);
      // R6 boundary: SP 6 is allowed
      run_int(2'b00, 8'h21, 16'h0800, 16'h0006, 16'h0303, 16'h0404, 16'h0100, 1'b0);

      // R6: SP 3 shuts down, later requests ignored
      run_int(2'b00, 8'h21, 16'h0900, 16'h0003, 16'h0505, 16'h0606, 16'h0200, 1'b0);
      req_kind = 2'b00; sp_in = 16'h0100; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk(shutdown && !busy && !done, "R6", "request ignored in shutdown",
          {29'h0, shutdown, busy, done}, 32'h4);

      do_reset();
      chk(shutdown == 1'b0, "R8", "reset clears shutdown", {31'h0, shutdown}, 32'h0);
      // R6: SP 5 and SP 1 also shut down
      run_int(2'b01, 8'h00, 16'h0900, 16'h0005, 16'h0505, 16'h0606, 16'h0000, 1'b0);
      do_reset();
      run_int(2'b00, 8'h21, 16'h0900, 16'h0001, 16'h0505, 16'h0606, 16'h0000, 1'b0);
      do_reset();
      // R6: an odd SP above the limit still enters
      run_int(2'b00, 8'h21, 16'h0900, 16'h0007, 16'h0909, 16'h0A0A, 16'h0300, 1'b0);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule